// File: doc/BRIEF.md
# Guard Predicate Bank with Paired Compare

This block keeps a bank of single-bit guard flags and the compare logic that sets them. A compare takes two 64-bit operands and a condition code. In one clock edge it writes the outcome into one named flag and the inverse of the outcome into a second named flag. Code can then place two alternative operations under the two flags, for example a subtract under one and an add under the other, and exactly one of them takes effect.

Each cycle up to three issue slots each name the flag that guards them. The block returns the flag values and a per-slot execute enable. An operation whose guard is false gets no enable and leaves no architectural trace. Flag 0 is tied true, so an unguarded operation names index 0.

Top module: `pred_regfile`

## Requirements
- R1: After synchronous reset, `guard_q` and `exec_en` are all zero, and every flag from 1 to 63 reads 0.
- R2: `cmp_cond` selects the test: 0 is equal, 1 is not-equal, 2 is signed less-than (a < b), 3 is unsigned less-than (a < b).
- R3: When `cmp_en` is high, the flag at `cmp_dst_t` takes the compare outcome and the flag at `cmp_dst_f` takes its inverse, both on the same edge.
- R4: Flag 0 always reads 1, and a compare that targets index 0 leaves it unchanged.
- R5: If `cmp_dst_t` equals `cmp_dst_f`, that flag takes the outcome, not the inverse.
- R6: A read in the same cycle as a compare write to the same flag returns the old value. The new value is seen by reads presented in the following cycle.
- R7: `exec_en[s]` is `slot_valid[s]` AND the guard flag of slot s. An invalid slot or a slot with a false guard gets no enable.
- R8: `guard_q` and `exec_en` are registered. They reflect the read indices and slot valids sampled at the previous rising edge.
- R9: With `cmp_en` low, no flag changes, whatever the operands and indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_en | input | 1 | Perform a compare and write two flags |
| cmp_a | input | 64 | First compare operand |
| cmp_b | input | 64 | Second compare operand |
| cmp_cond | input | 2 | Condition code (0 eq, 1 ne, 2 signed lt, 3 unsigned lt) |
| cmp_dst_t | input | 6 | Flag index that takes the outcome |
| cmp_dst_f | input | 6 | Flag index that takes the inverse outcome |
| slot_valid | input | 3 | An operation is issued in slot s |
| slot_pidx | input | 18 | Guard index of slot s at bits [6s+5:6s] |
| guard_q | output | 3 | Registered guard flag value per slot |
| exec_en | output | 3 | Registered execute enable per slot |

## Verification
Inputs presented before rising edge k produce their read results on `guard_q` and `exec_en` right after edge k, one cycle later. A compare presented before edge k is visible to reads presented before edge k+1. The bench drives each cycle's inputs on the falling edge and checks the outputs at the next falling edge. Its model computes expected guards from the flag state held before that cycle's compare, then applies the compare, so old-value reads and next-cycle visibility fall on the same cycles the design uses.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int unsigned OPND_W = 64;
  localparam int unsigned NPRED  = 64;
  localparam int unsigned NSLOT  = 3;
  localparam int unsigned IDX_W  = $clog2(NPRED);

  typedef enum logic [1:0] {
    CC_EQ  = 2'd0,
    CC_NE  = 2'd1,
    CC_SLT = 2'd2,
    CC_ULT = 2'd3
  } cmp_cond_e;
endpackage

// File: rtl/pred_compare.sv
module pred_compare
  import pred_pkg::*;
#(
  parameter int unsigned W = OPND_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  cmp_cond_e    cond,
  output logic         res
);
  logic eq, slt, ult;

  always_comb begin
    eq  = (a == b);
    slt = ($signed(a) < $signed(b));
    ult = (a < b);
    unique case (cond)
      CC_EQ:   res = eq;
      CC_NE:   res = !eq;
      CC_SLT:  res = slt;
      default: res = ult;
    endcase
  end
endmodule

// File: rtl/pred_bank.sv
module pred_bank #(
  parameter int unsigned N   = 64,
  parameter int unsigned NRD = 3,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_t,
  input  logic [IW-1:0]       wr_f,
  input  logic                wr_val,
  input  logic [NRD-1:0][IW-1:0] rd_idx,
  output logic [NRD-1:0]      rd_bit
);
  localparam logic [N-1:0] RST_VAL = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] bits;
  logic [N-1:0] nxt;

  // Inverse first, outcome second, so a shared index keeps the outcome.
  always_comb begin
    nxt = bits;
    if (wr_en) begin
      nxt[wr_f] = !wr_val;
      nxt[wr_t] = wr_val;
    end
    nxt[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) bits <= RST_VAL;
    else     bits <= nxt;
  end

  genvar r;
  generate
    for (r = 0; r < NRD; r++) begin : g_rd
      assign rd_bit[r] = bits[rd_idx[r]];
    end
  endgenerate

  // R3 R5
  outcome_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_t != '0) |=> bits[$past(wr_t)] == $past(wr_val));

  // R3
  inverse_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_f != '0 && wr_f != wr_t) |=> bits[$past(wr_f)] == !$past(wr_val));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bits));
endmodule

// File: rtl/pred_guard.sv
module pred_guard #(
  parameter int unsigned NS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] valid,
  input  logic [NS-1:0] gbit,
  output logic [NS-1:0] guard_q,
  output logic [NS-1:0] exec_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      guard_q <= '0;
      exec_en <= '0;
    end else begin
      guard_q <= gbit;
      exec_en <= valid & gbit;
    end
  end

  genvar s;
  generate
    for (s = 0; s < NS; s++) begin : g_chk
      // R7
      squash_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        !valid[s] |=> !exec_en[s]);
      // R7
      squash_false_chk: assert property (@(posedge clk) disable iff (rst)
        !gbit[s] |=> !exec_en[s]);
    end
  endgenerate
endmodule

// File: rtl/pred_regfile.sv
module pred_regfile
  import pred_pkg::*;
#(
  parameter int unsigned W  = OPND_W,
  parameter int unsigned NP = NPRED,
  parameter int unsigned NS = NSLOT,
  localparam int unsigned IW = $clog2(NP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_en,
  input  logic [W-1:0]     cmp_a,
  input  logic [W-1:0]     cmp_b,
  input  logic [1:0]       cmp_cond,
  input  logic [IW-1:0]    cmp_dst_t,
  input  logic [IW-1:0]    cmp_dst_f,
  input  logic [NS-1:0]    slot_valid,
  input  logic [NS*IW-1:0] slot_pidx,
  output logic [NS-1:0]    guard_q,
  output logic [NS-1:0]    exec_en
);
  logic                   cmp_res;
  logic [NS-1:0][IW-1:0]  rd_idx;
  logic [NS-1:0]          rd_bit;

  genvar s;
  generate
    for (s = 0; s < NS; s++) begin : g_idx
      assign rd_idx[s] = slot_pidx[s*IW +: IW];
    end
  endgenerate

  pred_compare #(.W(W)) cmp_i (
    .a    (cmp_a),
    .b    (cmp_b),
    .cond (cmp_cond_e'(cmp_cond)),
    .res  (cmp_res)
  );

  pred_bank #(.N(NP), .NRD(NS)) bank_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cmp_en),
    .wr_t   (cmp_dst_t),
    .wr_f   (cmp_dst_f),
    .wr_val (cmp_res),
    .rd_idx (rd_idx),
    .rd_bit (rd_bit)
  );

  pred_guard #(.NS(NS)) guard_i (
    .clk     (clk),
    .rst     (rst),
    .valid   (slot_valid),
    .gbit    (rd_bit),
    .guard_q (guard_q),
    .exec_en (exec_en)
  );

  // R4
  zero_guard_true_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_valid[0] && slot_pidx[IW-1:0] == '0) |=> exec_en[0]);
endmodule

// File: tb/pred_regfile_tb_top.sv
`timescale 1ns/1ps
module pred_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmp_en;
  logic [63:0] cmp_a, cmp_b;
  logic [1:0]  cmp_cond;
  logic [5:0]  cmp_dst_t, cmp_dst_f;
  logic [2:0]  slot_valid;
  logic [17:0] slot_pidx;
  logic [2:0]  guard_q, exec_en;

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          done = 0;
  bit          model [64];

  always #10 clk = ~clk;

  pred_regfile dut_i (
    .clk(clk), .rst(rst), .cmp_en(cmp_en), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .cmp_cond(cmp_cond), .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f),
    .slot_valid(slot_valid), .slot_pidx(slot_pidx),
    .guard_q(guard_q), .exec_en(exec_en)
  );

  function automatic bit ref_cmp(logic [63:0] a, logic [63:0] b, logic [1:0] c);
    case (c)
      2'd0: return a == b;
      2'd1: return a != b;
      2'd2: return $signed(a) < $signed(b);
      default: return a < b;
    endcase
  endfunction

  // One cycle: drive on falling edge, compute expectation from old state,
  // update model, then check at the next falling edge.
  task automatic cycle(input bit en, input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] c, input logic [5:0] t, input logic [5:0] f,
                       input logic [2:0] v, input logic [5:0] i0, input logic [5:0] i1,
                       input logic [5:0] i2, input string tag);
    logic [2:0] eg, ee;
    bit r;
    cmp_en = en; cmp_a = a; cmp_b = b; cmp_cond = c;
    cmp_dst_t = t; cmp_dst_f = f; slot_valid = v; slot_pidx = {i2, i1, i0};
    eg = {model[i2], model[i1], model[i0]};
    ee = eg & v;
    if (en) begin
      r = ref_cmp(a, b, c);
      if (f != 0) model[f] = !r;
      if (t != 0) model[t] = r;
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (guard_q !== eg || exec_en !== ee) begin
      errors++;
      $display("FAIL %s: guard_q=%b exec_en=%b expected guard_q=%b exec_en=%b",
               tag, guard_q, exec_en, eg, ee);
    end
  endtask

  task automatic rd(input logic [2:0] v, input logic [5:0] i0, input logic [5:0] i1,
                    input logic [5:0] i2, input string tag);
    cycle(1'b0, 64'h0, 64'h0, 2'd0, 6'd0, 6'd0, v, i0, i1, i2, tag);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) model[k] = (k == 0);
    rst = 1'b1; cmp_en = 0; cmp_a = 0; cmp_b = 0; cmp_cond = 0;
    cmp_dst_t = 0; cmp_dst_f = 0; slot_valid = 0; slot_pidx = 0;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    checks++;
    if (guard_q !== 3'b000 || exec_en !== 3'b000) begin
      errors++;
      $display("FAIL R1: guard_q=%b exec_en=%b expected 000 000", guard_q, exec_en);
    end
    rst = 1'b0;
    rd(3'b111, 6'd1, 6'd2, 6'd63, "R1");
    rd(3'b111, 6'd0, 6'd0, 6'd0, "R4 read");

    // R2 R3: every condition, true and false outcome
    for (int c = 0; c < 4; c++) begin
      cycle(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, c[1:0], 6'd5, 6'd6,
            3'b000, 6'd0, 6'd0, 6'd0, "R3 write");
      rd(3'b111, 6'd5, 6'd6, 6'd0, "R2 R3 neg-vs-pos");
      cycle(1'b1, 64'd42, 64'd42, c[1:0], 6'd7, 6'd8,
            3'b000, 6'd0, 6'd0, 6'd0, "R3 write");
      rd(3'b111, 6'd7, 6'd8, 6'd0, "R2 R3 equal");
      cycle(1'b1, 64'd3, 64'd9, c[1:0], 6'd11, 6'd12,
            3'b000, 6'd0, 6'd0, 6'd0, "R3 write");
      rd(3'b111, 6'd11, 6'd12, 6'd0, "R2 R3 small-vs-large");
    end

    // R4: write attempts on flag 0
    cycle(1'b1, 64'd1, 64'd2, 2'd0, 6'd0, 6'd13, 3'b000, 6'd0, 6'd0, 6'd0, "R4 write");
    rd(3'b111, 6'd0, 6'd13, 6'd0, "R4");
    cycle(1'b1, 64'd1, 64'd1, 2'd0, 6'd14, 6'd0, 3'b000, 6'd0, 6'd0, 6'd0, "R4 write");
    rd(3'b111, 6'd0, 6'd14, 6'd0, "R4");

    // R5: same destination
    cycle(1'b1, 64'd4, 64'd4, 2'd0, 6'd9, 6'd9, 3'b000, 6'd0, 6'd0, 6'd0, "R5 write");
    rd(3'b111, 6'd9, 6'd9, 6'd0, "R5 true");
    cycle(1'b1, 64'd4, 64'd4, 2'd1, 6'd9, 6'd9, 3'b000, 6'd0, 6'd0, 6'd0, "R5 write");
    rd(3'b111, 6'd9, 6'd9, 6'd0, "R5 false");

    // R6: read during write sees old, next cycle new
    cycle(1'b1, 64'd0, 64'd1, 2'd3, 6'd10, 6'd15, 3'b111, 6'd10, 6'd15, 6'd0, "R6 old");
    rd(3'b111, 6'd10, 6'd15, 6'd0, "R6 new");
    cycle(1'b1, 64'd1, 64'd0, 2'd3, 6'd10, 6'd15, 3'b111, 6'd10, 6'd15, 6'd0, "R6 old");
    rd(3'b111, 6'd10, 6'd15, 6'd0, "R6 new");

    // R7: squash by invalid slot and by false guard
    rd(3'b000, 6'd0, 6'd0, 6'd0, "R7 invalid slots");
    rd(3'b010, 6'd15, 6'd10, 6'd0, "R7 mixed");

    // R9: disabled compare changes nothing
    cmp_en = 0;
    cycle(1'b0, 64'd5, 64'd5, 2'd0, 6'd10, 6'd15, 3'b000, 6'd0, 6'd0, 6'd0, "R9 idle");
    rd(3'b111, 6'd10, 6'd15, 6'd0, "R9");

    // R8 plus all: random traffic
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = ($urandom % 3 == 0) ? a : {$urandom, $urandom};
      if ($urandom % 4 == 0) b = {~a[63], a[62:0]};
      cycle($urandom % 4 != 0, a, b, 2'($urandom), 6'($urandom % 20), 6'($urandom % 20),
            3'($urandom), 6'($urandom % 20), 6'($urandom % 20), 6'($urandom % 20),
            "R8 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule